// File: doc/BRIEF.md
# SPI Master Engine with Received-Packet Limit

This block drives the master side of a four-wire serial link. It divides the system clock down to a serial clock and drives an active-low slave select. It moves one byte out and one byte in at the same time: it takes each outgoing byte from a show-ahead transmit queue, and it hands each incoming byte to a receive queue. Both queues lie outside the block. Serial clock mode is fixed: the clock idles low, the slave samples on the rising edge, and data changes after the falling edge.

A configuration port holds three settings: a clock divider, a packet-limit enable, and a packet limit. When the limit is enabled, the engine counts the packets it delivers. Once the count reaches the limit, it stops the serial clock and sets a sticky halted flag. Changing the configuration does not release the halt. Only a soft reset releases it, and the soft reset keeps the configuration, or a hard reset does, which returns the configuration to its defaults.

The engine never drops data. It does not start a packet while the transmit queue is empty. It holds a finished packet, with the clock parked low, while the receive queue is full.

Top module: `spi_pkt_master`

## Requirements
- R1: `sclk` is low whenever the link is idle. Each high phase of `sclk` lasts exactly `cfg_div`+1 cycles of `clk`.
- R2: `ss_n` is high after reset and whenever `run` is low. It goes low at least one half period before the first rising edge of `sclk`, and it is low at every rising edge.
- R3: Each byte popped from the transmit queue (`tx_pop` pulse) appears on `mosi` most significant bit first. `mosi` changes only after falling edges, so it is stable at each rising edge.
- R4: `miso` is sampled on each rising edge, with the first bit taken as the most significant. After the eighth falling edge, the assembled byte is presented on `rx_data` together with a one-cycle `rx_push` pulse.
- R5: While `tx_empty` is high, no packet starts and `sclk` stays low. `ss_n` remains low as long as `run` stays high, and transfers resume when data arrives.
- R6: A completed packet is held while `rx_full` is high: there is no `rx_push` and no further `sclk` edge. The packet is pushed once `rx_full` falls.
- R7: With the limit enabled, the engine stops after exactly `cfg_limit` pushed packets. At that point it raises `halted`, pops no more bytes, makes no more `sclk` edges, and returns `ss_n` high.
- R8: With the limit disabled, transfers continue for as long as bytes are queued, whatever the value of `cfg_limit`, and `halted` stays low.
- R9: While halted, writes to the configuration (including a larger limit) produce no `sclk` edge, and `halted` stays set.
- R10: `soft_rst` clears the packet count, `halted` and the transfer state, so `ss_n` goes high and `sclk` goes low. The configuration is kept, so the next run obeys the same divider and limit.
- R11: `rst` clears everything including the configuration: the divider becomes 0 (half period of one cycle), the limit is disabled, and the limit value becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Hard reset, synchronous, active high; clears configuration too |
| soft_rst | input | 1 | Soft reset, synchronous, active high; keeps configuration |
| cfg_we | input | 1 | Loads the three configuration fields |
| cfg_div | input | DIV_W | Half period of `sclk` minus one, in `clk` cycles |
| cfg_lim_en | input | 1 | Enables the received-packet limit |
| cfg_limit | input | CNT_W | Number of packets after which the engine halts |
| run | input | 1 | Requests transfers; slave select follows it |
| tx_empty | input | 1 | Transmit queue has no data |
| tx_data | input | DW | Head of the transmit queue (show-ahead) |
| tx_pop | output | 1 | One-cycle pulse: head byte was taken |
| rx_full | input | 1 | Receive queue has no room |
| rx_push | output | 1 | One-cycle pulse: `rx_data` holds a received byte |
| rx_data | output | DW | Received byte |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| halted | output | 1 | Sticky: the packet limit was reached |

## Verification
The hardest state to reach is a halt followed by attempts to restart. The engine must reach its limit while bytes are still queued, ignore a new limit written while halted, and then, after a soft reset, enforce the retained limit again. The stimulus sweeps every divider from 0 to 3 against limits 1 to 3, always queuing two bytes more than the limit. After each halt it writes a larger limit, and at the end of the sweep it soft-resets and runs again on the last configuration. The receive stall is reached by holding `rx_full` high while a single byte shifts, so the packet is caught between its last clock edge and its push.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;

  // Transfer sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,   // select high, clock low
    ST_LEAD,   // select low, one half period before first edge
    ST_GAP,    // between packets, waiting for transmit data
    ST_LOW,    // clock low half period
    ST_HIGH,   // clock high half period
    ST_PUSH    // byte complete, waiting for receive room
  } xfer_state_t;

endpackage

// File: rtl/spi_halfper.sv
module spi_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (clr || !en || tick) cnt <= '0;
    else                    cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          shift,
  input  logic          sample,
  input  logic          sin,
  output logic          sout,
  output logic [DW-1:0] pout
);

  logic [DW-1:0] out_q;
  logic [DW-1:0] in_q;

  assign sout = out_q[DW-1];
  assign pout = in_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (load)       out_q <= din;
      else if (shift) out_q <= {out_q[DW-2:0], 1'b0};
      if (sample)     in_q  <= {in_q[DW-2:0], sin};
    end
  end

endmodule

// File: rtl/spi_pkt_limit.sv
module spi_pkt_limit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             pkt_done,
  input  logic             lim_en,
  input  logic [CNT_W-1:0] limit,
  output logic             halted
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_nxt;

  assign count_nxt = count + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (clr) begin
      count  <= '0;
      halted <= 1'b0;
    end else if (pkt_done) begin
      count <= count_nxt;
      if (lim_en && (count_nxt == limit)) halted <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
  import spi_pkt_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_lim_en,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             run,
  input  logic             tx_empty,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [DW-1:0]    rx_data,
  output logic             sclk,
  output logic             ss_n,
  output logic             mosi,
  input  logic             miso,
  output logic             halted
);

  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

  // configuration, cleared by hard reset only
  logic [DIV_W-1:0] div_q;
  logic             lim_en_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      lim_en_q <= 1'b0;
      limit_q  <= '0;
    end else if (cfg_we) begin
      div_q    <= cfg_div;
      lim_en_q <= cfg_lim_en;
      limit_q  <= cfg_limit;
    end
  end

  xfer_state_t      state;
  logic [BIT_W-1:0] bitc;
  logic             clr;
  logic             tick;
  logic             half_en;
  logic             load;
  logic             smp;
  logic             shf;
  logic             pkt_done;
  logic [DW-1:0]    rx_byte;

  assign clr      = rst || soft_rst;
  assign half_en  = (state == ST_LEAD) || (state == ST_LOW) || (state == ST_HIGH);
  assign load     = (state == ST_GAP) && run && !halted && !tx_empty;
  assign smp      = (state == ST_LOW) && tick;
  assign shf      = (state == ST_HIGH) && tick && (bitc != LAST_BIT);
  assign pkt_done = (state == ST_PUSH) && !rx_full;

  spi_halfper #(.DIV_W(DIV_W)) i_halfper (
    .clk  (clk),
    .clr  (clr),
    .en   (half_en),
    .div  (div_q),
    .tick (tick)
  );

  spi_byte_shift #(.DW(DW)) i_shift (
    .clk    (clk),
    .clr    (clr),
    .load   (load),
    .din    (tx_data),
    .shift  (shf),
    .sample (smp),
    .sin    (miso),
    .sout   (mosi),
    .pout   (rx_byte)
  );

  spi_pkt_limit #(.CNT_W(CNT_W)) i_limit (
    .clk      (clk),
    .clr      (clr),
    .pkt_done (pkt_done),
    .lim_en   (lim_en_q),
    .limit    (limit_q),
    .halted   (halted)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      state   <= ST_IDLE;
      bitc    <= '0;
      sclk    <= 1'b0;
      ss_n    <= 1'b1;
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (run && !halted) begin
            ss_n  <= 1'b0;
            state <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) state <= ST_GAP;
        end
        ST_GAP: begin
          if (!run || halted) begin
            ss_n  <= 1'b1;
            state <= ST_IDLE;
          end else if (!tx_empty) begin
            tx_pop <= 1'b1;
            bitc   <= '0;
            state  <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (bitc == LAST_BIT) begin
              state <= ST_PUSH;
            end else begin
              bitc  <= bitc + BIT_W'(1);
              state <= ST_LOW;
            end
          end
        end
        ST_PUSH: begin
          if (!rx_full) begin
            rx_push <= 1'b1;
            rx_data <= rx_byte;
            state   <= ST_GAP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_pkt_master_chk.sv
module spi_pkt_master_chk (
  input logic clk,
  input logic rst,
  input logic soft_rst,
  input logic sclk,
  input logic ss_n,
  input logic halted,
  input logic tx_empty,
  input logic tx_pop,
  input logic rx_full,
  input logic rx_push
);

  p_clk_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    ss_n |-> !sclk);

  p_select_leads_clk_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $past(!ss_n));

  p_no_pop_when_empty_r5: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !$past(tx_empty));

  p_no_push_when_full_r6: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !$past(rx_full));

  p_quiet_after_halt_r7: assert property (@(posedge clk) disable iff (rst)
    $past(halted) |-> !$rose(sclk));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(halted) && !$past(soft_rst)) |-> halted);

  p_soft_clears_r10: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst) |-> (ss_n && !sclk && !halted));

endmodule

bind spi_pkt_master spi_pkt_master_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .soft_rst (soft_rst),
  .sclk     (sclk),
  .ss_n     (ss_n),
  .halted   (halted),
  .tx_empty (tx_empty),
  .tx_pop   (tx_pop),
  .rx_full  (rx_full),
  .rx_push  (rx_push)
);

// File: tb/test_spi_pkt_master.sv
module test_spi_pkt_master;

  logic        clk = 1'b0;
  logic        rst, soft_rst, cfg_we, cfg_lim_en, run, rx_full;
  logic [7:0]  cfg_div;
  logic [15:0] cfg_limit;
  logic        tx_empty, tx_pop, rx_push, sclk, ss_n, mosi, halted;
  logic        miso = 1'b0;
  logic [7:0]  tx_data, rx_data;

  always #5 clk = ~clk;

  spi_pkt_master i_spi_pkt_master (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_div(cfg_div), .cfg_lim_en(cfg_lim_en), .cfg_limit(cfg_limit),
    .run(run), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso), .halted(halted)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mgen(input int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [7:0] sgen(input int i);
    return 8'(i * 73) ^ 8'hC5;
  endfunction

  // transmit queue model (show-ahead)
  logic [7:0] txq [256];
  int tx_n = 0;
  int pops = 0;
  assign tx_empty = (pops == tx_n);
  assign tx_data  = txq[8'(pops)];
  always @(negedge clk) if (tx_pop === 1'b1) pops++;

  task automatic push_tx(input int n);
    for (int k = 0; k < n; k++) begin
      txq[8'(tx_n)] = mgen(tx_n);
      tx_n++;
    end
  endtask

  // slave model: samples mosi on rising edge, drives miso after falling edge
  int sbit = 0, sidx = 0, midx = 0, rises = 0;
  logic [7:0] srx = 8'h00;
  always @(posedge sclk) begin
    rises++;
    chk(ss_n == 1'b0, "R2 select low at edge", int'(ss_n), 0);
    srx = {srx[6:0], mosi};
    if (sbit == 7) begin
      chk(srx == mgen(midx), "R3 mosi byte", int'(srx), int'(mgen(midx)));
      midx++;
      sidx++;
      sbit = 0;
    end else begin
      sbit++;
    end
  end

  always @(negedge sclk or negedge ss_n) begin
    logic [7:0] t;
    t = sgen(sidx);
    miso = t[3'(7 - sbit)];
  end

  // receive monitor (R4)
  int rxn = 0;
  always @(negedge clk) begin
    if (rx_push === 1'b1) begin
      chk(rx_data == sgen(rxn), "R4 rx byte", int'(rx_data), int'(sgen(rxn)));
      rxn++;
    end
  end

  // high phase length monitor (R1)
  int hi = 0;
  int cur_div = 0;
  always @(negedge clk) begin
    if (sclk === 1'b1) hi++;
    else if (hi != 0) begin
      chk(hi == cur_div + 1, "R1 high phase", hi, cur_div + 1);
      hi = 0;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input int d, input bit en, input int lim);
    @(negedge clk);
    cfg_div = 8'(d); cfg_lim_en = en; cfg_limit = 16'(lim); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_div = d;
  endtask

  task automatic soft_pulse();
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_halt(input int maxc);
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (halted === 1'b1) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r0, p0, rs;
    rst = 1'b1; soft_rst = 1'b0; cfg_we = 1'b0; cfg_div = '0;
    cfg_lim_en = 1'b0; cfg_limit = '0; run = 1'b0; rx_full = 1'b0;
    wait_cycles(4);
    rst = 1'b0;
    wait_cycles(1);
    chk(sclk == 1'b0, "R1 reset clock low", int'(sclk), 0);
    chk(ss_n == 1'b1, "R2 reset select high", int'(ss_n), 1);
    chk(halted == 1'b0, "R7 reset not halted", int'(halted), 0);
    chk(rx_push == 1'b0, "R4 reset no push", int'(rx_push), 0);

    // sweep divider and limit (R7, R9)
    for (int d = 0; d < 4; d++) begin
      for (int l = 1; l < 4; l++) begin
        run = 1'b0;
        tx_n = pops;
        soft_pulse();
        chk(halted == 1'b0, "R10 soft clears halt", int'(halted), 0);
        cfg_write(d, 1'b1, l);
        push_tx(l + 2);
        r0 = rxn; p0 = pops;
        run = 1'b1;
        wait_halt((l + 3) * (20 * (d + 1) + 8) + 50);
        wait_cycles(2 * (d + 1) + 10);
        chk(rxn - r0 == l, "R7 packets before halt", rxn - r0, l);
        chk(halted == 1'b1, "R7 halted flag", int'(halted), 1);
        chk(ss_n == 1'b1, "R7 select released", int'(ss_n), 1);
        chk(pops - p0 == l, "R7 pops before halt", pops - p0, l);
        rs = rises;
        cfg_write(d, 1'b1, l + 4);
        wait_cycles(100);
        chk(rises == rs, "R9 no edges after rewrite", rises - rs, 0);
        chk(halted == 1'b1, "R9 halt kept", int'(halted), 1);
      end
    end

    // R10: soft reset keeps the last written limit (7) and divider (3)
    run = 1'b0;
    tx_n = pops;
    soft_pulse();
    chk(ss_n == 1'b1, "R10 select high", int'(ss_n), 1);
    chk(halted == 1'b0, "R10 halt cleared", int'(halted), 0);
    push_tx(10);
    r0 = rxn;
    run = 1'b1;
    wait_halt(10 * 90 + 100);
    wait_cycles(20);
    chk(rxn - r0 == 7, "R10 retained limit", rxn - r0, 7);
    chk(halted == 1'b1, "R10 halted again", int'(halted), 1);

    // R8 and R5: unlimited, then empty queue stall
    run = 1'b0;
    tx_n = pops;
    soft_pulse();
    cfg_write(1, 1'b0, 2);
    push_tx(5);
    r0 = rxn;
    run = 1'b1;
    wait_cycles(5 * 48 + 100);
    chk(rxn - r0 == 5, "R8 unlimited packets", rxn - r0, 5);
    chk(halted == 1'b0, "R8 not halted", int'(halted), 0);
    chk(ss_n == 1'b0, "R5 select held while empty", int'(ss_n), 0);
    rs = rises;
    wait_cycles(100);
    chk(rises == rs, "R5 no edges while empty", rises - rs, 0);
    chk(sclk == 1'b0, "R5 clock parked low", int'(sclk), 0);
    push_tx(2);
    wait_cycles(2 * 48 + 50);
    chk(rxn - r0 == 7, "R5 resume after refill", rxn - r0, 7);

    // R6: receive queue full
    rx_full = 1'b1;
    r0 = rxn; rs = rises;
    push_tx(1);
    wait_cycles(200);
    chk(rxn == r0, "R6 no push while full", rxn - r0, 0);
    chk(rises - rs == 8, "R6 edges of held byte", rises - rs, 8);
    chk(sclk == 1'b0, "R6 clock parked low", int'(sclk), 0);
    rx_full = 1'b0;
    wait_cycles(10);
    chk(rxn - r0 == 1, "R6 push after release", rxn - r0, 1);

    // R11: hard reset clears configuration
    cfg_write(2, 1'b1, 1);
    run = 1'b0;
    tx_n = pops;
    wait_cycles(5);
    rst = 1'b1;
    wait_cycles(3);
    rst = 1'b0;
    cur_div = 0;
    wait_cycles(1);
    chk(ss_n == 1'b1, "R11 select high", int'(ss_n), 1);
    chk(halted == 1'b0, "R11 not halted", int'(halted), 0);
    push_tx(4);
    r0 = rxn;
    run = 1'b1;
    wait_cycles(4 * 24 + 100);
    chk(rxn - r0 == 4, "R11 limit cleared", rxn - r0, 4);
    chk(halted == 1'b0, "R11 no halt", int'(halted), 0);
    run = 1'b0;
    wait_cycles(10);
    chk(ss_n == 1'b1, "R2 select high when run low", int'(ss_n), 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule